// File: doc/BRIEF.md
# Banked UART Register Address Decoder

This block holds the programmable registers of one serial channel and decodes a 3-bit register address into them. Three register sets share the same eight addresses. The current line control byte chooses which set an access reaches. With its top bit clear, the ordinary set is reached. With its top bit set, the baud divisor bytes replace the two lowest addresses. When it holds the unlock key BFh, the extended feature byte and the four flow-control character bytes also come into view. Addresses that the active set does not claim reach the ordinary register at that address.

Some upper bits of the interrupt enable, FIFO control and modem control registers form a second tier. They accept writes only while bit 4 of the extended feature byte is 1. Receive and transmit holding data, line status, modem status and the interrupt identification byte are produced elsewhere. This block routes them to the read bus and issues one-cycle strobes when the holding addresses are accessed. Every stored register drives an output, and the line control and extended feature fields are also brought out decoded.

Top module: `uart_regbank`

## Requirements
- R1: After reset, interrupt enable, FIFO control, line control, modem control, both divisor bytes, extended feature and the four flow characters read 00h. The scratch byte reads FFh.
- R2: With line control bit 7 = 0, reads map addresses as follows: 1 = interrupt enable, 2 = isr_i, 3 = line control, 4 = modem control, 5 = lsr_i, 6 = msr_i, 7 = scratch. Writes map address 2 to FIFO control and addresses 1, 3, 4 and 7 to the register read there.
- R3: With line control bit 7 = 0, address 0 has no storage. A read returns rhr_i and pulses rhr_rd_o for that cycle. A write pulses thr_wr_o for that cycle.
- R4: With line control bit 7 = 1, address 0 reads and writes the divisor low byte and address 1 the divisor high byte. Neither holding strobe fires in this case.
- R5: With line control = BFh, address 2 reads and writes the extended feature byte. Addresses 4, 5, 6 and 7 reach Xon1, Xon2, Xoff1 and Xoff2 in that order.
- R6: With line control bit 7 = 1 and a value other than BFh, addresses 2 to 7 behave as in R2. With BFh, address 3 still reaches line control.
- R7: While extended feature bit 4 = 0, writes leave these bits unchanged: interrupt enable bits 7:4, FIFO control bits 5:4 and modem control bits 7:5. The remaining bits of those registers take the written value.
- R8: While extended feature bit 4 = 1, all bits of those three registers take the written value.
- R9: Line control fields come out as follows: bits 1:0 word length, bit 2 stop bits, bit 3 parity enable, bit 4 even parity, bit 5 forced parity, bit 6 break, bit 7 divisor access.
- R10: Extended feature fields come out as follows: bit 7 automatic CTS, bit 6 automatic RTS, bit 5 special-character detect, bits 3:0 software flow-control mode.
- R11: With rd_en and wr_en both low, rdata is 00h, both strobes are low and no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 3 | Register address |
| rd_en | input | 1 | Read access this cycle |
| wr_en | input | 1 | Write access this cycle |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational) |
| rhr_i | input | 8 | Receive holding data from the receive path |
| isr_i | input | 8 | Interrupt identification byte |
| lsr_i | input | 8 | Line status byte |
| msr_i | input | 8 | Modem status byte |
| rhr_rd_o | output | 1 | Receive holding read strobe |
| thr_wr_o | output | 1 | Transmit holding write strobe (data on wdata) |
| ier_o | output | 8 | Interrupt enable register |
| fcr_o | output | 8 | FIFO control register |
| lcr_o | output | 8 | Line control register |
| mcr_o | output | 8 | Modem control register |
| dll_o | output | 8 | Divisor low byte |
| dlm_o | output | 8 | Divisor high byte |
| efr_o | output | 8 | Extended feature register |
| xon1_o | output | 8 | Xon character 1 |
| xon2_o | output | 8 | Xon character 2 |
| xoff1_o | output | 8 | Xoff character 1 |
| xoff2_o | output | 8 | Xoff character 2 |
| word_len_o | output | 2 | Decoded word length field |
| stop_bits_o | output | 1 | Decoded stop bit select |
| par_en_o | output | 1 | Decoded parity enable |
| par_even_o | output | 1 | Decoded even parity select |
| par_force_o | output | 1 | Decoded forced parity |
| brk_o | output | 1 | Decoded break control |
| auto_cts_o | output | 1 | Decoded automatic CTS enable |
| auto_rts_o | output | 1 | Decoded automatic RTS enable |
| spec_chr_o | output | 1 | Decoded special-character detect enable |
| swfc_mode_o | output | 4 | Decoded software flow-control mode |

## Verification
The same address sweep runs under four line control values: a plain format byte, 80h, 83h and BFh. The results show whether the bank choice comes from bit 7 alone or from the full key comparison. Addresses 2, 4 and 7 under 80h tell fall-through to the ordinary set apart from decoding into the key-only registers. All-ones writes are made to the gated registers before and after unlocking, which separates the gated bit ranges from the freely writable ones. Idle cycles with the address left on 0 show that the holding strobes need an access enable.

// File: rtl/uart_regbank.sv
module uart_regbank #(
  parameter logic [7:0] ENH_KEY = 8'hBF,
  parameter logic [7:0] SPR_RST = 8'hFF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] addr,
  input  logic       rd_en,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic [7:0] rhr_i,
  input  logic [7:0] isr_i,
  input  logic [7:0] lsr_i,
  input  logic [7:0] msr_i,
  output logic       rhr_rd_o,
  output logic       thr_wr_o,
  output logic [7:0] ier_o,
  output logic [7:0] fcr_o,
  output logic [7:0] lcr_o,
  output logic [7:0] mcr_o,
  output logic [7:0] dll_o,
  output logic [7:0] dlm_o,
  output logic [7:0] efr_o,
  output logic [7:0] xon1_o,
  output logic [7:0] xon2_o,
  output logic [7:0] xoff1_o,
  output logic [7:0] xoff2_o,
  output logic [1:0] word_len_o,
  output logic       stop_bits_o,
  output logic       par_en_o,
  output logic       par_even_o,
  output logic       par_force_o,
  output logic       brk_o,
  output logic       auto_cts_o,
  output logic       auto_rts_o,
  output logic       spec_chr_o,
  output logic [3:0] swfc_mode_o
);

  localparam logic [7:0] IER_GATE = 8'hF0;
  localparam logic [7:0] FCR_GATE = 8'h30;
  localparam logic [7:0] MCR_GATE = 8'hE0;

  typedef enum logic [3:0] {
    S_HOLD, S_IER, S_IDFC, S_LCR, S_MCR, S_LSR, S_MSR, S_SPR,
    S_DLL, S_DLM, S_EFR, S_XON1, S_XON2, S_XOFF1, S_XOFF2
  } sel_t;

  logic [7:0] ier_q, fcr_q, lcr_q, mcr_q, spr_q, dll_q, dlm_q, efr_q;
  logic [7:0] xon1_q, xon2_q, xoff1_q, xoff2_q;
  sel_t sel;

  wire dlab      = lcr_q[7];
  wire key_open  = (lcr_q == ENH_KEY);
  wire gate_open = efr_q[4];

  always_comb begin
    case (addr)
      3'd0: sel = dlab ? S_DLL : S_HOLD;
      3'd1: sel = dlab ? S_DLM : S_IER;
      3'd2: sel = key_open ? S_EFR : S_IDFC;
      3'd3: sel = S_LCR;
      3'd4: sel = key_open ? S_XON1 : S_MCR;
      3'd5: sel = key_open ? S_XON2 : S_LSR;
      3'd6: sel = key_open ? S_XOFF1 : S_MSR;
      default: sel = key_open ? S_XOFF2 : S_SPR;
    endcase
  end

  logic [7:0] rd_mux;
  always_comb begin
    case (sel)
      S_HOLD:  rd_mux = rhr_i;
      S_IER:   rd_mux = ier_q;
      S_IDFC:  rd_mux = isr_i;
      S_LCR:   rd_mux = lcr_q;
      S_MCR:   rd_mux = mcr_q;
      S_LSR:   rd_mux = lsr_i;
      S_MSR:   rd_mux = msr_i;
      S_SPR:   rd_mux = spr_q;
      S_DLL:   rd_mux = dll_q;
      S_DLM:   rd_mux = dlm_q;
      S_EFR:   rd_mux = efr_q;
      S_XON1:  rd_mux = xon1_q;
      S_XON2:  rd_mux = xon2_q;
      S_XOFF1: rd_mux = xoff1_q;
      default: rd_mux = xoff2_q;
    endcase
  end

  assign rdata    = rd_en ? rd_mux : 8'h00;
  assign rhr_rd_o = rd_en && (sel == S_HOLD);
  assign thr_wr_o = wr_en && (sel == S_HOLD);

  function automatic logic [7:0] gated(input logic [7:0] old_v, input logic [7:0] new_v,
                                       input logic [7:0] mask, input logic open);
    return open ? new_v : ((old_v & mask) | (new_v & ~mask));
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ier_q   <= 8'h00;
      fcr_q   <= 8'h00;
      lcr_q   <= 8'h00;
      mcr_q   <= 8'h00;
      spr_q   <= SPR_RST;
      dll_q   <= 8'h00;
      dlm_q   <= 8'h00;
      efr_q   <= 8'h00;
      xon1_q  <= 8'h00;
      xon2_q  <= 8'h00;
      xoff1_q <= 8'h00;
      xoff2_q <= 8'h00;
    end else if (wr_en) begin
      case (sel)
        S_IER:   ier_q   <= gated(ier_q, wdata, IER_GATE, gate_open);
        S_IDFC:  fcr_q   <= gated(fcr_q, wdata, FCR_GATE, gate_open);
        S_LCR:   lcr_q   <= wdata;
        S_MCR:   mcr_q   <= gated(mcr_q, wdata, MCR_GATE, gate_open);
        S_SPR:   spr_q   <= wdata;
        S_DLL:   dll_q   <= wdata;
        S_DLM:   dlm_q   <= wdata;
        S_EFR:   efr_q   <= wdata;
        S_XON1:  xon1_q  <= wdata;
        S_XON2:  xon2_q  <= wdata;
        S_XOFF1: xoff1_q <= wdata;
        S_XOFF2: xoff2_q <= wdata;
        default: ;
      endcase
    end
  end

  assign ier_o   = ier_q;
  assign fcr_o   = fcr_q;
  assign lcr_o   = lcr_q;
  assign mcr_o   = mcr_q;
  assign dll_o   = dll_q;
  assign dlm_o   = dlm_q;
  assign efr_o   = efr_q;
  assign xon1_o  = xon1_q;
  assign xon2_o  = xon2_q;
  assign xoff1_o = xoff1_q;
  assign xoff2_o = xoff2_q;

  assign word_len_o  = lcr_q[1:0];
  assign stop_bits_o = lcr_q[2];
  assign par_en_o    = lcr_q[3];
  assign par_even_o  = lcr_q[4];
  assign par_force_o = lcr_q[5];
  assign brk_o       = lcr_q[6];

  assign auto_cts_o  = efr_q[7];
  assign auto_rts_o  = efr_q[6];
  assign spec_chr_o  = efr_q[5];
  assign swfc_mode_o = efr_q[3:0];

endmodule

// File: rtl/uart_regbank_chk.sv
module uart_regbank_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] addr,
  input logic       rd_en,
  input logic       wr_en,
  input logic [7:0] wdata,
  input logic       rhr_rd_o,
  input logic       thr_wr_o,
  input logic [7:0] ier_o,
  input logic [7:0] lcr_o,
  input logic [7:0] mcr_o,
  input logic [7:0] dll_o,
  input logic [7:0] efr_o
);

  assert_thr_bank_R3: assert property (@(posedge clk) disable iff (!rst_n)
    thr_wr_o |-> (wr_en && addr == 3'd0 && !lcr_o[7]));

  assert_rhr_bank_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rhr_rd_o |-> (rd_en && addr == 3'd0 && !lcr_o[7]));

  assert_dll_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && lcr_o[7] && addr == 3'd0) |=> (dll_o == $past(wdata)));

  assert_efr_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && lcr_o == 8'hBF && addr == 3'd2) |=> (efr_o == $past(wdata)));

  assert_ier_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !lcr_o[7] && addr == 3'd1 && !efr_o[4]) |=> (ier_o[7:4] == $past(ier_o[7:4])));

  assert_mcr_open_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && lcr_o != 8'hBF && addr == 3'd4 && efr_o[4]) |=> (mcr_o == $past(wdata)));

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(ier_o) && $stable(lcr_o) && $stable(mcr_o) && $stable(dll_o) && $stable(efr_o)));

endmodule

bind uart_regbank uart_regbank_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en), .wdata(wdata),
  .rhr_rd_o(rhr_rd_o), .thr_wr_o(thr_wr_o), .ier_o(ier_o), .lcr_o(lcr_o),
  .mcr_o(mcr_o), .dll_o(dll_o), .efr_o(efr_o)
);

// File: tb/uart_regbank_tb_top.sv
`timescale 1ns/1ps
module uart_regbank_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [7:0] rhr_i = 8'h3C, isr_i = 8'hC1, lsr_i = 8'h60, msr_i = 8'hA0;
  logic rhr_rd_o, thr_wr_o;
  logic [7:0] ier_o, fcr_o, lcr_o, mcr_o, dll_o, dlm_o, efr_o, xon1_o, xon2_o, xoff1_o, xoff2_o;
  logic [1:0] word_len_o;
  logic stop_bits_o, par_en_o, par_even_o, par_force_o, brk_o;
  logic auto_cts_o, auto_rts_o, spec_chr_o;
  logic [3:0] swfc_mode_o;

  always #4 clk = ~clk;

  uart_regbank dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .rhr_i(rhr_i), .isr_i(isr_i), .lsr_i(lsr_i), .msr_i(msr_i),
    .rhr_rd_o(rhr_rd_o), .thr_wr_o(thr_wr_o), .ier_o(ier_o), .fcr_o(fcr_o), .lcr_o(lcr_o),
    .mcr_o(mcr_o), .dll_o(dll_o), .dlm_o(dlm_o), .efr_o(efr_o), .xon1_o(xon1_o),
    .xon2_o(xon2_o), .xoff1_o(xoff1_o), .xoff2_o(xoff2_o), .word_len_o(word_len_o),
    .stop_bits_o(stop_bits_o), .par_en_o(par_en_o), .par_even_o(par_even_o),
    .par_force_o(par_force_o), .brk_o(brk_o), .auto_cts_o(auto_cts_o),
    .auto_rts_o(auto_rts_o), .spec_chr_o(spec_chr_o), .swfc_mode_o(swfc_mode_o)
  );

  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;

  // reference state
  int m_ier, m_fcr, m_lcr, m_mcr, m_spr, m_dll, m_dlm, m_efr;
  int m_fc[4];

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int m_read(input int a);
    bit dl = (m_lcr / 128) % 2 == 1;
    bit key = (m_lcr == 'hBF);
    if (dl && a == 0) return m_dll;
    if (dl && a == 1) return m_dlm;
    if (key && a == 2) return m_efr;
    if (key && a >= 4) return m_fc[a-4];
    case (a)
      0: return rhr_i;
      1: return m_ier;
      2: return isr_i;
      3: return m_lcr;
      4: return m_mcr;
      5: return lsr_i;
      6: return msr_i;
      default: return m_spr;
    endcase
  endfunction

  function automatic int merge(input int old_v, input int new_v, input int locked);
    if ((m_efr / 16) % 2 == 1) return new_v;
    return (old_v & locked) | (new_v & (255 - locked));
  endfunction

  task automatic m_write(input int a, input int d);
    bit dl = (m_lcr / 128) % 2 == 1;
    bit key = (m_lcr == 'hBF);
    if (dl && a == 0) m_dll = d;
    else if (dl && a == 1) m_dlm = d;
    else if (key && a == 2) m_efr = d;
    else if (key && a >= 4) m_fc[a-4] = d;
    else case (a)
      1: m_ier = merge(m_ier, d, 'hF0);
      2: m_fcr = merge(m_fcr, d, 'h30);
      3: m_lcr = d;
      4: m_mcr = merge(m_mcr, d, 'hE0);
      7: m_spr = d;
      default: ;
    endcase
  endtask

  task automatic cmp_regs(input string req);
    check(req, "ier", ier_o, m_ier);
    check(req, "fcr", fcr_o, m_fcr);
    check(req, "lcr", lcr_o, m_lcr);
    check(req, "mcr", mcr_o, m_mcr);
    check(req, "dll", dll_o, m_dll);
    check(req, "dlm", dlm_o, m_dlm);
    check(req, "efr", efr_o, m_efr);
    check(req, "xon1", xon1_o, m_fc[0]);
    check(req, "xon2", xon2_o, m_fc[1]);
    check(req, "xoff1", xoff1_o, m_fc[2]);
    check(req, "xoff2", xoff2_o, m_fc[3]);
    check("R9", "word_len", word_len_o, m_lcr % 4);
    check("R9", "stop", stop_bits_o, (m_lcr / 4) % 2);
    check("R9", "par_en", par_en_o, (m_lcr / 8) % 2);
    check("R9", "par_even", par_even_o, (m_lcr / 16) % 2);
    check("R9", "par_force", par_force_o, (m_lcr / 32) % 2);
    check("R9", "brk", brk_o, (m_lcr / 64) % 2);
    check("R10", "auto_cts", auto_cts_o, (m_efr / 128) % 2);
    check("R10", "auto_rts", auto_rts_o, (m_efr / 64) % 2);
    check("R10", "spec_chr", spec_chr_o, (m_efr / 32) % 2);
    check("R10", "swfc", swfc_mode_o, m_efr % 16);
  endtask

  // one bus cycle: drive, compare combinational and stored outputs, then clock the model
  task automatic op(input bit rd, input bit wr, input int a, input int d, input string req);
    bit hold;
    @(negedge clk);
    rd_en = rd; wr_en = wr; addr = a[2:0]; wdata = d[7:0];
    #1;
    hold = ((m_lcr / 128) % 2 == 0) && a == 0;
    check(req, "rdata", rdata, rd ? m_read(a) : 0);
    check(req, "rhr_rd", rhr_rd_o, int'(rd && hold));
    check(req, "thr_wr", thr_wr_o, int'(wr && hold));
    cmp_regs(req);
    @(posedge clk);
    if (wr) m_write(a, d);
  endtask

  task automatic wr(input int a, input int d, input string req); op(1'b0, 1'b1, a, d, req); endtask
  task automatic rd(input int a, input string req); op(1'b1, 1'b0, a, 0, req); endtask

  initial begin
    m_ier = 0; m_fcr = 0; m_lcr = 0; m_mcr = 0; m_spr = 'hFF; m_dll = 0; m_dlm = 0; m_efr = 0;
    foreach (m_fc[i]) m_fc[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    // R1 literal reset values
    check("R1", "ier", ier_o, 0); check("R1", "fcr", fcr_o, 0);
    check("R1", "lcr", lcr_o, 0); check("R1", "mcr", mcr_o, 0);
    check("R1", "dll", dll_o, 0); check("R1", "efr", efr_o, 0);
    check("R1", "xoff2", xoff2_o, 0);
    rd(7, "R1");
    check("R1", "scratch", rdata, 'hFF);
    // R2 general bank
    for (int a = 1; a < 8; a++) rd(a, "R2");
    wr(7, 'h5A, "R2"); rd(7, "R2");
    wr(3, 'h1B, "R2"); rd(3, "R9");
    // R3 holding strobes
    rd(0, "R3"); wr(0, 'hA7, "R3");
    // R7 gate closed
    wr(1, 'hFF, "R7"); rd(1, "R7");
    wr(2, 'hFF, "R7"); wr(4, 'hFF, "R7"); rd(4, "R7");
    // R11 idle with address 0
    op(1'b0, 1'b0, 0, 'h99, "R11"); op(1'b0, 1'b0, 1, 'h00, "R11");
    // R4 / R6 divisor bank without key
    wr(3, 'h80, "R4");
    wr(0, 'h0C, "R4"); wr(1, 'h03, "R4"); rd(0, "R4"); rd(1, "R4");
    for (int a = 2; a < 8; a++) rd(a, "R6");
    wr(7, 'h33, "R6"); wr(2, 'h01, "R6"); wr(4, 'h02, "R6"); rd(7, "R6");
    wr(3, 'h83, "R6"); rd(5, "R6"); rd(3, "R6");
    // R5 key bank
    wr(3, 'hBF, "R5");
    wr(2, 'hE5, "R10"); rd(2, "R5");
    for (int a = 4; a < 8; a++) wr(a, 'h11 * a, "R5");
    for (int a = 0; a < 8; a++) rd(a, "R5");
    wr(0, 'h60, "R5"); wr(2, 'hD3, "R10");
    // R8 gate open
    wr(3, 'h07, "R8");
    wr(1, 'hF5, "R8"); wr(2, 'h31, "R8"); wr(4, 'hE3, "R8"); rd(1, "R8"); rd(4, "R8");
    for (int a = 4; a < 8; a++) rd(a, "R2");
    op(1'b0, 1'b0, 0, 0, "R11");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule